// File: doc/BRIEF.md
# Byte-Wide Flash Command and Status Controller

This block sits between a simple asynchronous-style host bus and a byte-wide, sector-organised flash array model. The host bus is sampled on the clock. It has a chip enable, a write enable and an output enable, all active low, plus a byte address, write data, read data and an active-low reset. The host writes short byte sequences to start operations. A two-write unlock (0xAA, then 0x55) precedes each command byte, and the address of an unlock or command write is ignored. Single-byte programs and multi-sector or whole-array erases then run as timed internal algorithms. Their durations are parameter cycle counts, not real pulse times.

While an algorithm runs, the ready output is low and every read returns a status byte instead of array data. Bit 7 of the status is a polling bit and bit 6 flips on each status read. When the algorithm finishes, the controller drops back to read mode by itself. An erase can be put on hold so that the host can read or program sectors outside the erase set, and then resumed. A protection input with one bit per group of four adjacent sectors blocks program and erase in those sectors. A low-supply input blocks all writes.

Top module: `flash_ctrl`

## Requirements
- R1: While `rstN` is low the controller returns to read mode, `ready` is 1 and `rdData` is 0x00. A reset taken during a program or erase aborts it, and afterwards the controller accepts new commands normally.
- R2: Each command is the byte sequence 0xAA, 0x55, command byte, and any write address is accepted during it. A wrong byte in an unlock position cancels the sequence, and the writes that follow are treated as the start of a new sequence.
- R3: Command 0xA0 followed by one write stores that write's data byte at that write's address. `ready` is then low for exactly PROG_CYCLES clock cycles, and afterwards the byte reads back.
- R4: During a program, a read returns a status byte. Bit 7 is the complement of bit 7 of the byte being programmed, and bits 5..0 are 0.
- R5: Bit 6 of the status byte alternates between successive status reads.
- R6: Command 0x80, a second unlock, and then 0x30 erase the sector addressed by the 0x30 write. Each further 0x30 write made within WINDOW_CYCLES cycles of the previous one adds its sector to the erase set. Status bit 7 reads 0 during an erase. At the end, every byte of the erased sectors reads 0xFF and every other sector is unchanged.
- R7: Command 0x80, a second unlock, and then 0x10 erase every unprotected sector. `ready` is low during this erase.
- R8: Bit g of `protMask` protects sectors 4g to 4g+3. A program aimed at a protected sector is ignored and leaves `ready` high, and an erase leaves protected sectors unchanged.
- R9: The sequence 0xAA, 0x55, 0xB0 during an erase suspends it and raises `ready`. While the erase is suspended, reads outside the erase set return array data, reads inside it return status (bit 7 is 0, bit 6 toggles), and a program outside the set runs normally. The sequence 0xAA, 0x55, 0x30 resumes the erase and completes it.
- R10: While `lowSupply` is 1, host writes have no effect.
- R11: `rdData` changes only on a clock edge where `ceN` and `oeN` are low and `weN` is high. The new value is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wrData | input | 8 | Command or program data |
| lowSupply | input | 1 | Supply-low flag; blocks writes |
| protMask | input | NUM_GROUPS | One protect bit per four-sector group |
| rdData | output | 8 | Registered read data or status |
| ready | output | 1 | High when no algorithm is running |

## Verification
The hardest situation to reach from the ports is a program that runs inside a suspended erase. The suspend has to land after the sector-select window has closed but before the first targeted sector has finished. The bench cannot see the window end, because both phases look busy at the ports. It therefore waits a fixed WINDOW_CYCLES+2 cycles after the last 0x30 write and then issues the suspend. The per-sector erase time is sized so that this timing falls well inside the erase of the first selected sector. Two status reads, a normal array read, a program into a third sector and a resume then complete the scenario.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PGM_ARM,
    OP_ERS_ARM,
    OP_ERS_WIN,
    OP_PROG,
    OP_ERASE,
    OP_SUSP,
    OP_SUSP_ARM
  } opState_t;

  // strobes from the sequencer to the array datapath
  typedef struct packed {
    logic latchPgm;
    logic commitPgm;
    logic zeroSector;
    logic fillSector;
  } dpStrobe_t;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] CMD_PGM    = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_HOLD   = 8'hB0;

endpackage

// File: rtl/fc_array.sv
module fc_array
  import fc_pkg::*;
#(
  parameter int NUM_SECTORS  = 32,
  parameter int SECTOR_BYTES = 4,
  localparam int SEC_W  = $clog2(NUM_SECTORS),
  localparam int OFF_W  = $clog2(SECTOR_BYTES),
  localparam int ADDR_W = SEC_W + OFF_W
) (
  input  logic              clk,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostData,
  input  logic [SEC_W-1:0]  sectorSel,
  output logic [7:0]        arrayByte,
  output logic              pgmBit7
);
  localparam int TOTAL = NUM_SECTORS * SECTOR_BYTES;

  logic [7:0]        mem [TOTAL];
  logic [ADDR_W-1:0] pgmAddr;
  logic [7:0]        pgmByte;

  always_ff @(posedge clk) begin
    if (strb.latchPgm) begin
      pgmAddr <= hostAddr;
      pgmByte <= hostData;
    end
    if (strb.commitPgm) mem[pgmAddr] <= pgmByte;
    if (strb.zeroSector || strb.fillSector) begin
      for (int b = 0; b < SECTOR_BYTES; b++)
        mem[{sectorSel, OFF_W'(b)}] <= strb.fillSector ? 8'hFF : 8'h00;
    end
  end

  assign arrayByte = mem[hostAddr];
  assign pgmBit7   = pgmByte[7];
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int NUM_SECTORS       = 32,
  parameter int SECTORS_PER_GROUP = 4,
  parameter int PROG_CYCLES       = 8,
  parameter int PRE_CYCLES        = 4,
  parameter int ERASE_CYCLES      = 12,
  parameter int WINDOW_CYCLES     = 6,
  localparam int SEC_W      = $clog2(NUM_SECTORS),
  localparam int NUM_GROUPS = NUM_SECTORS / SECTORS_PER_GROUP,
  localparam int GRP_SH     = $clog2(SECTORS_PER_GROUP)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  weN,
  input  logic                  oeN,
  input  logic                  lowSupply,
  input  logic [SEC_W-1:0]      hostSector,
  input  logic [7:0]            hostData,
  input  logic [NUM_GROUPS-1:0] protMask,
  input  logic [7:0]            arrayByte,
  input  logic                  pgmBit7,
  output dpStrobe_t             strb,
  output logic [SEC_W-1:0]      sectorSel,
  output logic [7:0]            rdData,
  output logic                  ready
);
  localparam int CNT_W = $clog2(PROG_CYCLES + PRE_CYCLES + ERASE_CYCLES + WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERS_LAST  = CNT_W'(PRE_CYCLES + ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WINDOW_CYCLES - 1);

  opState_t               opState;
  logic [1:0]             unl;
  logic [CNT_W-1:0]       progCnt, ersCnt;
  logic [SEC_W-1:0]       curSector;
  logic [NUM_SECTORS-1:0] eraseMask, unprotAll;
  logic                   retSusp, toggle;
  logic                   wrEn, rdEn, hostProt, pgmOk, inSector, statusRead, pollBit;

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : gUnprot
    assign unprotAll[s] = !protMask[s / SECTORS_PER_GROUP];
  end

  always_comb begin
    wrEn       = !ceN && !weN && !lowSupply;
    rdEn       = !ceN && !oeN && weN;
    hostProt   = protMask[hostSector[SEC_W-1:GRP_SH]];
    pgmOk      = !hostProt && !(opState == OP_SUSP_ARM && eraseMask[hostSector]);
    inSector   = (opState == OP_ERASE) && eraseMask[curSector];
    statusRead = (opState == OP_PROG) || (opState == OP_ERASE) || (opState == OP_ERS_WIN) ||
                 ((opState == OP_SUSP || opState == OP_SUSP_ARM) && eraseMask[hostSector]);
    pollBit    = (opState == OP_PROG) ? !pgmBit7 : 1'b0;
    ready      = !((opState == OP_PROG) || (opState == OP_ERASE) || (opState == OP_ERS_WIN));
    strb.latchPgm   = wrEn && (opState == OP_PGM_ARM || opState == OP_SUSP_ARM) && pgmOk;
    strb.commitPgm  = (opState == OP_PROG) && (progCnt == PROG_LAST);
    strb.zeroSector = inSector && (ersCnt == PRE_LAST);
    strb.fillSector = inSector && (ersCnt == ERS_LAST);
    sectorSel       = curSector;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opState   <= OP_IDLE;
      unl       <= 2'd0;
      progCnt   <= '0;
      ersCnt    <= '0;
      curSector <= '0;
      eraseMask <= '0;
      retSusp   <= 1'b0;
      toggle    <= 1'b0;
      rdData    <= 8'h00;
    end else begin
      if (rdEn) begin
        if (statusRead) begin
          rdData <= {pollBit, toggle, 6'b0};
          toggle <= !toggle;
        end else begin
          rdData <= arrayByte;
        end
      end
      case (opState)
        OP_IDLE, OP_SUSP: if (wrEn) begin
          case (unl)
            2'd0: unl <= (hostData == KEY_FIRST) ? 2'd1 : 2'd0;
            2'd1: unl <= (hostData == KEY_SECOND) ? 2'd2 : 2'd0;
            default: begin
              unl <= 2'd0;
              if (opState == OP_IDLE) begin
                if (hostData == CMD_PGM) opState <= OP_PGM_ARM;
                else if (hostData == CMD_ESETUP) opState <= OP_ERS_ARM;
              end else begin
                if (hostData == CMD_PGM) opState <= OP_SUSP_ARM;
                else if (hostData == CMD_SECT) opState <= OP_ERASE;
              end
            end
          endcase
        end
        OP_PGM_ARM, OP_SUSP_ARM: if (wrEn) begin
          progCnt <= '0;
          retSusp <= (opState == OP_SUSP_ARM);
          if (pgmOk) opState <= OP_PROG;
          else opState <= (opState == OP_SUSP_ARM) ? OP_SUSP : OP_IDLE;
        end
        OP_ERS_ARM: if (wrEn) begin
          case (unl)
            2'd0: if (hostData == KEY_FIRST) unl <= 2'd1; else opState <= OP_IDLE;
            2'd1: if (hostData == KEY_SECOND) unl <= 2'd2;
                  else begin unl <= 2'd0; opState <= OP_IDLE; end
            default: begin
              unl       <= 2'd0;
              ersCnt    <= '0;
              curSector <= '0;
              if (hostData == CMD_CHIP) begin
                eraseMask <= unprotAll;
                opState   <= (|unprotAll) ? OP_ERASE : OP_IDLE;
              end else if (hostData == CMD_SECT) begin
                if (!hostProt) eraseMask[hostSector] <= 1'b1;
                opState <= OP_ERS_WIN;
              end else begin
                opState <= OP_IDLE;
              end
            end
          endcase
        end
        OP_ERS_WIN: begin
          if (wrEn) begin
            if (hostData == CMD_SECT) begin
              if (!hostProt) eraseMask[hostSector] <= 1'b1;
              ersCnt <= '0;
            end else begin
              eraseMask <= '0;
              opState   <= OP_IDLE;
            end
          end else if (ersCnt == WIN_LAST) begin
            ersCnt    <= '0;
            curSector <= '0;
            opState   <= (|eraseMask) ? OP_ERASE : OP_IDLE;
          end else begin
            ersCnt <= ersCnt + 1'b1;
          end
        end
        OP_PROG: begin
          if (progCnt == PROG_LAST) opState <= retSusp ? OP_SUSP : OP_IDLE;
          else progCnt <= progCnt + 1'b1;
        end
        OP_ERASE: begin
          if (!(|eraseMask)) begin
            opState <= OP_IDLE;
          end else begin
            if (!eraseMask[curSector]) begin
              curSector <= curSector + 1'b1;
            end else if (ersCnt == ERS_LAST) begin
              eraseMask[curSector] <= 1'b0;
              ersCnt    <= '0;
              curSector <= curSector + 1'b1;
            end else begin
              ersCnt <= ersCnt + 1'b1;
            end
            if (wrEn) begin
              case (unl)
                2'd0: unl <= (hostData == KEY_FIRST) ? 2'd1 : 2'd0;
                2'd1: unl <= (hostData == KEY_SECOND) ? 2'd2 : 2'd0;
                default: begin
                  unl <= 2'd0;
                  if (hostData == CMD_HOLD) opState <= OP_SUSP;
                end
              endcase
            end
          end
        end
        default: opState <= OP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import fc_pkg::*;
#(
  parameter int NUM_SECTORS       = 32,
  parameter int SECTOR_BYTES      = 4,
  parameter int SECTORS_PER_GROUP = 4,
  parameter int PROG_CYCLES       = 8,
  parameter int PRE_CYCLES        = 4,
  parameter int ERASE_CYCLES      = 12,
  parameter int WINDOW_CYCLES     = 6,
  localparam int SEC_W      = $clog2(NUM_SECTORS),
  localparam int OFF_W      = $clog2(SECTOR_BYTES),
  localparam int ADDR_W     = SEC_W + OFF_W,
  localparam int NUM_GROUPS = NUM_SECTORS / SECTORS_PER_GROUP
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  weN,
  input  logic                  oeN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wrData,
  input  logic                  lowSupply,
  input  logic [NUM_GROUPS-1:0] protMask,
  output logic [7:0]            rdData,
  output logic                  ready
);
  dpStrobe_t        strb;
  logic [SEC_W-1:0] sectorSel;
  logic [7:0]       arrayByte;
  logic             pgmBit7;

  fc_ctrl #(
    .NUM_SECTORS(NUM_SECTORS), .SECTORS_PER_GROUP(SECTORS_PER_GROUP),
    .PROG_CYCLES(PROG_CYCLES), .PRE_CYCLES(PRE_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .lowSupply(lowSupply), .hostSector(addr[ADDR_W-1:OFF_W]),
    .hostData(wrData), .protMask(protMask), .arrayByte(arrayByte),
    .pgmBit7(pgmBit7), .strb(strb), .sectorSel(sectorSel),
    .rdData(rdData), .ready(ready)
  );

  fc_array #(
    .NUM_SECTORS(NUM_SECTORS), .SECTOR_BYTES(SECTOR_BYTES)
  ) uArray (
    .clk(clk), .strb(strb), .hostAddr(addr), .hostData(wrData),
    .sectorSel(sectorSel), .arrayByte(arrayByte), .pgmBit7(pgmBit7)
  );
endmodule

// File: rtl/flash_ctrl_checker.sv
module flash_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       weN,
  input logic       oeN,
  input logic       lowSupply,
  input logic       ready,
  input logic [7:0] rdData
);
  logic rdEn;
  assign rdEn = !ceN && !oeN && weN;

  // R1: the first cycle out of reset shows read mode
  p_reset_read_mode_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ready && rdData == 8'h00));

  // R11: read data holds unless a read is strobed
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R10: with supply low an idle controller cannot become busy
  p_lowsupply_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ready && lowSupply) |=> ready);

  // R5: status reads one cycle apart show opposite toggle bits
  p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !ready) ##1 (!rdEn && !ready) ##1 (rdEn && !ready)
      |=> (rdData[6] != $past(rdData[6])));
endmodule

bind flash_ctrl flash_ctrl_checker uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
  .lowSupply(lowSupply), .ready(ready), .rdData(rdData)
);

// File: tb/flash_ctrl_test.sv
module flash_ctrl_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = 32, SB = 4, PROG = 8, WIN = 6, AW = 7, NG = 8, TOTAL = NS * SB;

  logic clk = 1'b0;
  logic rstN, ceN, weN, oeN, lowSupply, ready;
  logic [AW-1:0] addr;
  logic [7:0] wrData, rdData;
  logic [NG-1:0] protMask;

  int total = 0;
  int bad = 0;
  logic [7:0] model [TOTAL];

  always #2.5 clk = ~clk;

  flash_ctrl uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .wrData(wrData), .lowSupply(lowSupply), .protMask(protMask),
    .rdData(rdData), .ready(ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ceN = 1'b0; weN = 1'b0; addr = a; wrData = d;
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; addr = a;
    @(negedge clk); ceN = 1'b1; oeN = 1'b1; v = rdData;
  endtask

  task automatic cmd(input logic [7:0] c);
    wr(AW'($urandom), 8'hAA);
    wr(AW'($urandom), 8'h55);
    wr(AW'($urandom), c);
  endtask

  task automatic waitReady();
    int n = 0;
    while (!ready && n < 4000) begin @(negedge clk); n++; end
    chk("R3 ready returns after operation", {7'd0, ready}, 8'h01);
  endtask

  function automatic bit isProt(input logic [AW-1:0] a);
    return protMask[a[AW-1:4]];
  endfunction

  task automatic checkArray(input string req);
    logic [7:0] v;
    for (int a = 0; a < TOTAL; a++) begin
      rd(AW'(a), v);
      chk(req, v, model[a]);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, s1, s2;
    int n;
    void'($urandom(32'd2024));
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; addr = '0; wrData = '0;
    lowSupply = 1'b0; protMask = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {7'd0, ready}, 8'h01);
    chk("R1 rdData after reset", rdData, 8'h00);

    // whole-array erase with no protection
    cmd(8'h80); cmd(8'h10);
    chk("R7 busy during chip erase", {7'd0, ready}, 8'h00);
    waitReady();
    for (int a = 0; a < TOTAL; a++) model[a] = 8'hFF;
    checkArray("R7 array erased");

    // program timing
    cmd(8'hA0); wr(7'h05, 8'h5A);
    n = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk("R3 busy cycle count", 8'(n), 8'(PROG));
    model[5] = 8'h5A;
    rd(7'h05, v); chk("R3 program readback", v, 8'h5A);

    // status during program, data bit7 = 0
    cmd(8'hA0); wr(7'h21, 8'h3C);
    rd(7'h00, s1); rd(7'h7F, s2);
    chk("R4 poll bit complement", {7'd0, s1[7]}, 8'h01);
    chk("R4 low status bits zero", {2'b00, s1[5:0]}, 8'h00);
    chk("R5 toggle alternates", {7'd0, s2[6]}, {7'd0, ~s1[6]});
    waitReady(); model[8'h21] = 8'h3C;
    rd(7'h21, v); chk("R4 true data after completion", v, 8'h3C);

    // status during program, data bit7 = 1
    cmd(8'hA0); wr(7'h22, 8'hC3);
    rd(7'h22, s1);
    chk("R4 poll bit complement high data", {7'd0, s1[7]}, 8'h00);
    waitReady(); model[8'h22] = 8'hC3;

    // broken unlock
    wr(7'h11, 8'hAA); wr(7'h12, 8'h12); wr(7'h13, 8'hA0); wr(7'h30, 8'h3C);
    chk("R2 broken unlock stays ready", {7'd0, ready}, 8'h01);
    rd(7'h30, v); chk("R2 broken unlock no program", v, model[8'h30]);

    // low supply blocks writes
    lowSupply = 1'b1;
    cmd(8'hA0); wr(7'h31, 8'h00);
    chk("R10 no busy under low supply", {7'd0, ready}, 8'h01);
    lowSupply = 1'b0;
    rd(7'h31, v); chk("R10 byte unchanged", v, model[8'h31]);

    // protection
    cmd(8'hA0); wr(7'd33, 8'h77); waitReady(); model[33] = 8'h77;
    protMask = 8'h04;
    cmd(8'hA0); wr(7'd37, 8'h11);
    chk("R8 protected program stays ready", {7'd0, ready}, 8'h01);
    rd(7'd37, v); chk("R8 protected byte unchanged", v, model[37]);
    cmd(8'h80); cmd(8'h10); waitReady();
    for (int a = 0; a < TOTAL; a++) if (!isProt(AW'(a))) model[a] = 8'hFF;
    checkArray("R8 chip erase spares protected group");

    // constrained random programs against a protection pattern
    protMask = 8'h24;
    for (int i = 0; i < 30; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'($urandom_range(0, 63));
      d = 8'($urandom);
      cmd(8'hA0); wr(a, d);
      waitReady();
      if (!isProt(a)) model[a] = d;
      rd(a, v); chk("R3 R8 random program", v, model[a]);
    end

    // sector erase with window, suspend, program in another sector, resume
    protMask = '0;
    cmd(8'hA0); wr(7'd20, 8'h12); waitReady(); model[20] = 8'h12;
    cmd(8'hA0); wr(7'd36, 8'h34); waitReady(); model[36] = 8'h34;
    cmd(8'hA0); wr(7'd2,  8'h56); waitReady(); model[2]  = 8'h56;
    cmd(8'h80);
    wr(7'h01, 8'hAA); wr(7'h02, 8'h55);
    wr(7'd20, 8'h30); wr(7'd36, 8'h30);
    repeat (WIN + 2) @(negedge clk);
    rd(7'h00, s1);
    chk("R6 erase poll bit zero", {7'd0, s1[7]}, 8'h00);
    cmd(8'hB0);
    chk("R9 suspend raises ready", {7'd0, ready}, 8'h01);
    rd(7'd21, s1); rd(7'd21, s2);
    chk("R9 suspended target status bit7", {7'd0, s1[7]}, 8'h00);
    chk("R9 suspended target toggle", {7'd0, s2[6]}, {7'd0, ~s1[6]});
    rd(7'd2, v); chk("R9 read outside erase set", v, 8'h56);
    cmd(8'hA0); wr(7'd81, 8'h9A); waitReady();
    model[81] = 8'h9A;
    rd(7'd81, v); chk("R9 program while suspended", v, 8'h9A);
    cmd(8'h30);
    chk("R9 resume busy", {7'd0, ready}, 8'h00);
    waitReady();
    for (int a = 20; a < 24; a++) model[a] = 8'hFF;
    for (int a = 36; a < 40; a++) model[a] = 8'hFF;
    checkArray("R6 R9 erase set cleared, others kept");

    // reset during program
    cmd(8'hA0); wr(7'h40, 8'h00);
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 abort returns ready", {7'd0, ready}, 8'h01);
    chk("R1 abort clears read data", rdData, 8'h00);
    cmd(8'hA0); wr(7'h41, 8'h42); waitReady();
    rd(7'h41, v); chk("R1 commands accepted after abort", v, 8'h42);

    summary();
    $finish;
  end
endmodule